// File: doc/BRIEF.md
# Power-On Reset Sequencer with Restart on Configuration Faults

This block holds a configuration controller in reset after power-up. The supply-good indication must be present, and then a selectable wait must run out. Only after that does the block stop pulling low a shared open-drain enable line. Other agents on the board may also hold that line low. While any of them does, the block keeps its controller in reset.

Once released, the block watches the device being configured. The device may report a fault on its active-low status line. The data streamer may also signal that the last configuration byte has gone out while the device's done flag is still low. In either case the block pulls the enable line low again for a minimum pulse, runs the delay again and then releases the line a second time.

A separate permit flag gates test-port and programming instructions, and it is only high once the whole sequence has finished.

Top module: `por_sequencer`

## Requirements
- R1: When `supply_good` rises, it passes through a two-flop synchronizer, and the delay counter then starts. `oe_drive_low` stays 1 for exactly N+2 full clock periods after the rise, where N is the selected delay in cycles, and then goes to 0.
- R2: With `delay_sel` = 1, N is the short delay of 2·`CLK_KHZ` cycles. With `delay_sel` = 0, N is the long delay of 100·`CLK_KHZ` cycles.
- R3: `delay_sel` is read only at the moment the counter is loaded. A change to it while the delay runs has no effect on the release time.
- R4: While released, if `oe_line` reads low even though the block is not driving it, `ctrl_reset` goes to 1 and `cmd_permit` goes to 0. Both return two cycles after the line is freed. The delay is not restarted and `oe_drive_low` stays 0.
- R5: A low level on `supply_good` sets `oe_drive_low` and `ctrl_reset` to 1 and `cmd_permit` to 0 at once. After `supply_good` returns, the full delay runs again.
- R6: While released, a low level on `target_status_n`, after synchronization, starts an error sequence.
- R7: A one-cycle `data_end` pulse while the synchronized `target_done` is 0 starts an error sequence. The same pulse while `target_done` is 1 has no effect.
- R8: `cmd_permit` is the inverse of `ctrl_reset`. It is 0 whenever `oe_drive_low` is 1.
- R9: An error sequence drives `oe_drive_low` to 1 for `ERR_PULSE` cycles and then for the selected delay. That makes `ERR_PULSE`+N cycles in total before the block releases again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supply_good | input | 1 | Supply-good indication, active high; low level resets the block |
| delay_sel | input | 1 | 1 selects the short delay, 0 selects the long delay |
| oe_line | input | 1 | Readback of the shared open-drain enable line |
| target_status_n | input | 1 | Target device status, low reports a fault |
| target_done | input | 1 | Target device configuration-done flag |
| data_end | input | 1 | One-cycle strobe from the data streamer after the last byte |
| oe_drive_low | output | 1 | 1 pulls the shared enable line low |
| ctrl_reset | output | 1 | Reset to the configuration controller |
| cmd_permit | output | 1 | 1 permits test-port and programming instructions |

## Verification
The hardest situation to reach is an external hold of the enable line. It must not be confused with the block's own drive, which is still visible in the synchronized readback for two cycles after the release. The bench models the open-drain line as the AND of the block's drive and a bench pull-down. It asserts the pull-down only after the release has settled, then checks that the reset reappears while the block itself stays undriven. The error paths are reached by holding the status line low, or by pulsing end-of-data with the done flag low. The full low time is then counted cycle by cycle against the minimum pulse plus the delay.

// File: rtl/por_sequencer.sv
module por_sequencer #(
  parameter int CLK_KHZ   = 50000,
  parameter int ERR_PULSE = 1000
) (
  input  logic clk,
  input  logic supply_good,
  input  logic delay_sel,
  input  logic oe_line,
  input  logic target_status_n,
  input  logic target_done,
  input  logic data_end,
  output logic oe_drive_low,
  output logic ctrl_reset,
  output logic cmd_permit
);

  localparam int SHORT_CYC = 2 * CLK_KHZ;
  localparam int LONG_CYC  = 100 * CLK_KHZ;
  localparam int MAX_CYC   = (LONG_CYC > ERR_PULSE) ? LONG_CYC : ERR_PULSE;
  localparam int CW        = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {SUPPLY_WAIT, DELAY, RELEASED, ERROR_RESET} seq_t;

  seq_t          state;
  logic [CW-1:0] cnt;
  logic [1:0]    sup_s, sel_s, line_s, stat_s, done_s, drv_q;
  logic          ext_hold, cfg_fault;
  logic [CW-1:0] delay_load;

  always_ff @(posedge clk or negedge supply_good) begin
    if (!supply_good) begin
      sup_s  <= 2'b00;
      sel_s  <= 2'b00;
      line_s <= 2'b00;
      stat_s <= 2'b11;
      done_s <= 2'b00;
      drv_q  <= 2'b11;
    end else begin
      sup_s  <= {sup_s[0], 1'b1};
      sel_s  <= {sel_s[0], delay_sel};
      line_s <= {line_s[0], oe_line};
      stat_s <= {stat_s[0], target_status_n};
      done_s <= {done_s[0], target_done};
      drv_q  <= {drv_q[0], oe_drive_low};
    end
  end

  assign delay_load = sel_s[1] ? CW'(SHORT_CYC - 1) : CW'(LONG_CYC - 1);
  assign cfg_fault  = !stat_s[1] || (data_end && !done_s[1]);

  always_ff @(posedge clk or negedge supply_good) begin
    if (!supply_good) begin
      state <= SUPPLY_WAIT;
      cnt   <= '0;
    end else begin
      case (state)
        SUPPLY_WAIT:
          if (sup_s[1]) begin
            state <= DELAY;
            cnt   <= delay_load;
          end
        DELAY:
          if (cnt == '0) state <= RELEASED;
          else           cnt   <= cnt - 1'b1;
        RELEASED:
          if (cfg_fault) begin
            state <= ERROR_RESET;
            cnt   <= CW'(ERR_PULSE - 1);
          end
        default:
          if (cnt == '0) begin
            state <= DELAY;
            cnt   <= delay_load;
          end else begin
            cnt <= cnt - 1'b1;
          end
      endcase
    end
  end

  assign oe_drive_low = (state != RELEASED);
  assign ext_hold     = (state == RELEASED) && !line_s[1] && !drv_q[1];
  assign ctrl_reset   = oe_drive_low || ext_hold;
  assign cmd_permit   = !ctrl_reset;

  a_r8_permit_needs_release: assert property (@(posedge clk) disable iff (!supply_good)
    cmd_permit |-> !oe_drive_low);

  a_r5_no_release_without_supply: assert property (@(posedge clk) disable iff (!supply_good)
    !sup_s[1] |-> (oe_drive_low && ctrl_reset));

  a_r1_release_after_count: assert property (@(posedge clk) disable iff (!supply_good)
    $fell(oe_drive_low) |-> ($past(state) == DELAY && $past(cnt) == '0));

  a_r6_status_fault: assert property (@(posedge clk) disable iff (!supply_good)
    (state == RELEASED && !stat_s[1]) |=> (state == ERROR_RESET && oe_drive_low));

  a_r7_missing_done: assert property (@(posedge clk) disable iff (!supply_good)
    (state == RELEASED && data_end && !done_s[1]) |=> oe_drive_low);

  a_r4_hold_blocks_permit: assert property (@(posedge clk) disable iff (!supply_good)
    (state == RELEASED && !line_s[1] && !drv_q[1]) |-> !cmd_permit);

  a_r9_error_goes_to_delay: assert property (@(posedge clk) disable iff (!supply_good)
    ($past(state) == ERROR_RESET && state != ERROR_RESET) |-> state == DELAY);

endmodule

// File: tb/por_sequencer_bench.sv
module por_sequencer_bench;
  localparam int KHZ  = 2;
  localparam int PUL  = 4;
  localparam int NSH  = 2 * KHZ;
  localparam int NLG  = 100 * KHZ;

  logic clk = 0;
  logic supply_good = 0, delay_sel = 1, ext_pull = 0;
  logic target_status_n = 1, target_done = 0, data_end = 0;
  logic oe_line, oe_drive_low, ctrl_reset, cmd_permit;
  int checks = 0, fails = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;
  assign oe_line = !(oe_drive_low || ext_pull);

  por_sequencer #(.CLK_KHZ(KHZ), .ERR_PULSE(PUL)) u_por_sequencer (
    .clk(clk), .supply_good(supply_good), .delay_sel(delay_sel), .oe_line(oe_line),
    .target_status_n(target_status_n), .target_done(target_done), .data_end(data_end),
    .oe_drive_low(oe_drive_low), .ctrl_reset(ctrl_reset), .cmd_permit(cmd_permit));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (oe_drive_low && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_rise();
    for (int i = 0; i < 8; i++) begin
      if (oe_drive_low) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    #1;
    chk("R5 drive in reset", oe_drive_low, 1);
    chk("R5 ctrl_reset in reset", ctrl_reset, 1);
    chk("R8 permit in reset", cmd_permit, 0);
  endtask

  task automatic t_powerup(bit sel, int n_exp, string tag);
    int n;
    delay_sel = sel;
    @(negedge clk);
    supply_good = 1;
    @(negedge clk);
    count_high(n);
    chk(tag, n, n_exp + 2);
    chk("R8 permit after release", cmd_permit, 1);
    chk("R8 ctrl_reset after release", ctrl_reset, 0);
  endtask

  task automatic t_sel_change();
    int n;
    supply_good = 0;
    delay_sel = 1;
    @(negedge clk);
    supply_good = 1;
    repeat (5) @(negedge clk);
    delay_sel = 0;
    count_high(n);
    chk("R3 select change mid-delay", n + 4, NSH + 2);
  endtask

  task automatic t_ext_hold();
    bit drove = 0;
    @(negedge clk);
    ext_pull = 1;
    repeat (3) begin
      @(negedge clk);
      if (oe_drive_low) drove = 1;
    end
    chk("R4 ctrl_reset during hold", ctrl_reset, 1);
    chk("R4 permit during hold", cmd_permit, 0);
    repeat (20) begin
      @(negedge clk);
      if (oe_drive_low) drove = 1;
    end
    chk("R4 still held", ctrl_reset, 1);
    ext_pull = 0;
    repeat (3) begin
      @(negedge clk);
      if (oe_drive_low) drove = 1;
    end
    chk("R4 permit after hold", cmd_permit, 1);
    chk("R4 no self drive", drove, 0);
  endtask

  task automatic t_status_fault();
    int n;
    delay_sel = 1;
    @(negedge clk);
    target_status_n = 0;
    @(negedge clk);
    wait_rise();
    target_status_n = 1;
    chk("R6 status fault enters reset", oe_drive_low, 1);
    count_high(n);
    chk("R9 error low time", n, PUL + NSH);
    chk("R8 permit after error", cmd_permit, 1);
  endtask

  task automatic t_done_ok();
    bit drove = 0;
    target_done = 1;
    repeat (3) @(negedge clk);
    data_end = 1;
    @(negedge clk);
    data_end = 0;
    repeat (5) begin
      if (oe_drive_low) drove = 1;
      @(negedge clk);
    end
    chk("R7 end with done high ignored", drove, 0);
    chk("R7 permit kept", cmd_permit, 1);
  endtask

  task automatic t_done_missing();
    int n;
    target_done = 0;
    repeat (3) @(negedge clk);
    data_end = 1;
    @(negedge clk);
    data_end = 0;
    chk("R7 missing done enters reset", oe_drive_low, 1);
    count_high(n);
    chk("R9 error low time after missing done", n, PUL + NSH);
  endtask

  task automatic t_supply_drop();
    int n;
    @(negedge clk);
    supply_good = 0;
    #1;
    chk("R5 drop drive", oe_drive_low, 1);
    chk("R5 drop permit", cmd_permit, 0);
    @(negedge clk);
    supply_good = 1;
    repeat (3) @(negedge clk);
    supply_good = 0;
    @(negedge clk);
    supply_good = 1;
    @(negedge clk);
    count_high(n);
    chk("R5 delay restarts after drop", n, NSH + 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_powerup(1'b1, NSH, "R1 R2 short delay release");
    supply_good = 0;
    t_powerup(1'b0, NLG, "R2 long delay release");
    t_sel_change();
    t_ext_hold();
    t_status_fault();
    t_done_ok();
    t_done_missing();
    t_supply_drop();
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule